// File: doc/BRIEF.md
# Core/DMA Request Arbiter for an External Memory Port

This block decides which requester is handed the external memory port when more than one asks in the same cycle. The requesters are a set of processor cores and one DMA engine. Each core's request line already merges its instruction and data fetches, so every core request belongs to a single core class. The DMA request can also carry an urgent flag. A static configuration input picks the class that normally wins: the cores or the DMA.

A grant is one-hot and registered. It is issued in the cycle after the arbiter sees a request while idle. It is then held until the access sequencer pulses `xfer_done`. The arbiter returns to idle on the edge after that pulse and arbitrates again from there. When two or more cores compete and no DMA request wins, the cores take turns in round-robin order. The configuration input is only consulted while no grant is held, so changing it part way through a transfer has no effect on that transfer.

Top module: `mem_req_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `grant` becomes all zeros. After reset, the round-robin pointer favours core 0.
- R2: When the arbiter is idle and no request is present at a clock edge, `grant` stays all zeros.
- R3: `grant` never has more than one bit set. When the arbiter is idle and any request is present at an edge, exactly one bit is set after that edge.
- R4: Once issued, a grant holds its value until `xfer_done` is sampled high. It is all zeros after that edge, and new arbitration happens only from that idle state. `xfer_done` has no effect while idle.
- R5: With `dma_first`=0, a core request beats a simultaneous DMA request whose `dma_urgent` is 0.
- R6: With `dma_first`=0, a DMA request with `dma_urgent`=1 beats simultaneous core requests.
- R7: With `dma_first`=1, any DMA request beats simultaneous core requests, whatever the value of `dma_urgent`.
- R8: A DMA request with no core request present is granted in either mode.
- R9: When several cores request together and the DMA does not win, the grant goes to the first requesting core after the most recently granted core, in increasing index order with wrap-around. After reset that search starts at core 0.
- R10: A change of `dma_first` while a grant is held does not alter the held grant.
- R11: `grant` bit i (i < NUM_CORES) grants core i. Bit NUM_CORES grants the DMA. With two cores, the DMA grant is 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_first | input | 1 | 1: DMA outranks cores; 0: cores outrank non-urgent DMA |
| core_req | input | NUM_CORES | Per-core request (instruction or data fetch) |
| dma_req | input | 1 | DMA request |
| dma_urgent | input | 1 | Urgent qualifier for the DMA request |
| xfer_done | input | 1 | Completion pulse from the access sequencer |
| grant | output | NUM_CORES+1 | One-hot grant; bit NUM_CORES is the DMA |

## Verification
The embedded assertions check the following on every cycle:
- the grant is one-hot or zero;
- a held grant is stable until completion;
- the grant clears after `xfer_done`;
- an idle arbiter with no request stays idle;
- the class that wins under each mode and urgency combination is correct;
- round-robin picks are one-hot and are always among the requesting cores.

Some behaviour only shows in the bench's scenarios, where a behavioural reference model is compared with the design on every clock. This covers the exact rotation order across successive core grants, the pointer's starting point after reset, and the fact that a mode change mid-transfer is ignored but takes effect on the next arbitration.

// File: rtl/mem_arb_pkg.sv
// Shared types for the memory-port arbiter.
// Assumes: one DMA requester plus a parameterised number of cores.
package mem_arb_pkg;

    // Class that wins the port in a given arbitration cycle
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_CORE = 2'd1,
        WIN_DMA  = 2'd2
    } win_class_t;

endpackage

// File: rtl/mem_arb_class_sel.sv
// Decides between the core class and the DMA class.
// Assumes: the caller samples the result only while no grant is held,
// so the mode input is effectively read between grants.
module mem_arb_class_sel
    import mem_arb_pkg::*;
(
    input  logic       core_any,
    input  logic       dma_req,
    input  logic       dma_urgent,
    input  logic       dma_first,
    output win_class_t winner
);

    // Class priority: DMA wins if it ranks first, is urgent, or is alone
    always_comb begin
        if (dma_req && (dma_first || dma_urgent || !core_any))
            winner = WIN_DMA;
        else if (core_any)
            winner = WIN_CORE;
        else
            winner = WIN_NONE;
    end

endmodule

// File: rtl/mem_arb_core_rr.sv
// Round-robin pick among the core requesters.
// Assumes: 'take' is high only in a cycle where a core grant is issued;
// the pointer then records the picked core.
module mem_arb_core_rr #(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] req,
    input  logic                 take,
    output logic [NUM_CORES-1:0] pick
);

    localparam int PW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(NUM_CORES - 1);

    logic [PW-1:0] last_q;
    logic [PW-1:0] pick_idx;

    // Search from the core after the last granted one, wrapping around
    always_comb begin
        logic found;
        found    = 1'b0;
        pick     = '0;
        pick_idx = last_q;
        for (int off = 1; off <= NUM_CORES; off++) begin
            int idx;
            idx = (int'(last_q) + off) % NUM_CORES;
            if (!found && req[idx]) begin
                found     = 1'b1;
                pick[idx] = 1'b1;
                pick_idx  = PW'(idx);
            end
        end
    end

    // Pointer register: remember which core was granted last
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= LAST_IDX;
        else if (take)
            last_q <= pick_idx;
    end

    AST_RR_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick)); // R9
    AST_RR_PICK_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (pick & ~req) == '0); // R9
    AST_RR_PICK_IF_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|pick)); // R9

endmodule

// File: rtl/mem_req_arbiter.sv
// Grants the external memory port to one of NUM_CORES cores or the DMA.
// The grant is registered, one-hot, and held until the sequencer reports
// completion; arbitration runs only while idle.
// Assumes: xfer_done is a single-cycle pulse from the sequencer.
module mem_req_arbiter
    import mem_arb_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dma_first,
    input  logic [NUM_CORES-1:0] core_req,
    input  logic                 dma_req,
    input  logic                 dma_urgent,
    input  logic                 xfer_done,
    output logic [NUM_CORES:0]   grant
);

    localparam int NG      = NUM_CORES + 1;
    localparam int DMA_BIT = NUM_CORES;

    logic [NG-1:0]        grant_q;
    logic [NUM_CORES-1:0] core_pick;
    logic                 idle;
    win_class_t           winner;

    assign idle  = (grant_q == '0);
    assign grant = grant_q;

    mem_arb_class_sel u_class (
        .core_any   (|core_req),
        .dma_req    (dma_req),
        .dma_urgent (dma_urgent),
        .dma_first  (dma_first),
        .winner     (winner)
    );

    mem_arb_core_rr #(.NUM_CORES(NUM_CORES)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (core_req),
        .take  (idle && (winner == WIN_CORE)),
        .pick  (core_pick)
    );

    // Grant register: issue when idle, hold until done, then drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else if (idle) begin
            case (winner)
                WIN_DMA:  grant_q <= NG'(1) << DMA_BIT;
                WIN_CORE: grant_q <= {1'b0, core_pick};
                default:  grant_q <= '0;
            endcase
        end else if (xfer_done) begin
            grant_q <= '0;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R3
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && core_req == '0 && !dma_req) |=> (grant == '0)); // R2
    AST_IDLE_REQ_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && (|core_req || dma_req)) |=> $onehot(grant)); // R3
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !xfer_done) |=> $stable(grant)); // R4
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && xfer_done) |=> (grant == '0)); // R4
    AST_CORE_BEATS_PLAIN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && !dma_first && dma_req && !dma_urgent && |core_req)
        |=> (!grant[DMA_BIT] && |grant[NUM_CORES-1:0])); // R5
    AST_URGENT_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && !dma_first && dma_req && dma_urgent) |=> grant[DMA_BIT]); // R6
    AST_DMA_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && dma_first && dma_req) |=> grant[DMA_BIT]); // R7
    AST_LONE_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && dma_req && core_req == '0) |=> grant[DMA_BIT]); // R8

endmodule

// File: tb/mem_req_arbiter_test.sv
`timescale 1ns/1ps
module mem_req_arbiter_test;

    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dma_first;
    logic [NC-1:0] core_req;
    logic          dma_req;
    logic          dma_urgent;
    logic          xfer_done;
    logic [NC:0]   grant;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state: -1 idle, 0..NC-1 core, NC dma
    int m_owner = -1;
    int m_last  = NC - 1;

    always #2.5 clk = ~clk;

    mem_req_arbiter #(.NUM_CORES(NC)) uut (
        .clk(clk), .rst_n(rst_n), .dma_first(dma_first), .core_req(core_req),
        .dma_req(dma_req), .dma_urgent(dma_urgent), .xfer_done(xfer_done),
        .grant(grant)
    );

    function automatic logic [NC:0] owner_vec(int o);
        logic [NC:0] v;
        v = '0;
        if (o >= 0) v[o] = 1'b1;
        return v;
    endfunction

    // Behavioural next-state of the reference model, evaluated at an edge
    task automatic model_edge();
        if (!rst_n) begin
            m_owner = -1;
            m_last  = NC - 1;
        end else if (m_owner < 0) begin
            if (dma_req && (dma_first || dma_urgent || core_req == '0)) begin
                m_owner = NC;
            end else if (core_req != '0) begin
                for (int k = 1; k <= NC; k++) begin
                    int c;
                    c = (m_last + k) % NC;
                    if (m_owner < 0 && core_req[c]) m_owner = c;
                end
                m_last = m_owner;
            end
        end else if (xfer_done) begin
            m_owner = -1;
        end
    endtask

    task automatic check(string tag, logic [NC:0] exp);
        checks++;
        if (grant !== exp) begin
            errors++;
            $display("FAIL %s: grant=%b expected=%b at %0t", tag, grant, exp, $time);
        end
    endtask

    // One clock: inputs already driven at negedge; advance and compare
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, owner_vec(m_owner));
    endtask

    task automatic drive(logic df, logic [NC-1:0] cr, logic dr, logic du, logic dn);
        dma_first = df; core_req = cr; dma_req = dr; dma_urgent = du; xfer_done = dn;
    endtask

    initial begin
        drive(0, '0, 0, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst_n = 1'b1;
        check("R1 idle after reset", 3'b000);

        drive(0, '0, 0, 0, 1);
        step("R2 no request, stray done (R4)");
        step("R2 no request");

        // both cores: core 0 first after reset
        drive(0, 2'b11, 0, 0, 0);
        step("R9 first pick core0");
        check("R9 core0 explicit", 3'b001);
        drive(1, 2'b11, 1, 0, 0);
        step("R10 mode change while held");
        step("R4 hold");
        check("R10 grant kept", 3'b001);
        drive(0, 2'b11, 0, 0, 1);
        step("R4 done clears");
        check("R4 cleared", 3'b000);
        drive(0, 2'b11, 0, 0, 0);
        step("R9 rotate to core1");
        check("R9 core1 explicit", 3'b010);
        drive(0, 2'b11, 0, 0, 1);
        step("R4 done");
        drive(0, 2'b11, 0, 0, 0);
        step("R9 back to core0");
        drive(0, 2'b00, 0, 0, 1);
        step("R4 done");

        // core vs plain DMA, core-first mode
        drive(0, 2'b10, 1, 0, 0);
        step("R5 core beats plain dma");
        check("R5 core1 explicit", 3'b010);
        drive(0, 2'b00, 0, 0, 1);
        step("R4 done");

        // urgent DMA
        drive(0, 2'b11, 1, 1, 0);
        step("R6 urgent dma wins");
        check("R11 dma bit", 3'b100);
        drive(0, 2'b00, 0, 0, 1);
        step("R4 done");

        // DMA-first mode
        drive(1, 2'b11, 1, 0, 0);
        step("R7 dma first");
        check("R7 dma explicit", 3'b100);
        drive(1, 2'b00, 0, 0, 1);
        step("R4 done");

        // lone DMA in core-first mode
        drive(0, 2'b00, 1, 0, 0);
        step("R8 lone dma");
        check("R8 dma explicit", 3'b100);
        drive(0, 2'b00, 0, 0, 1);
        step("R4 done");

        // random traffic compared on every clock
        for (int n = 0; n < 3000; n++) begin
            drive(1'($urandom_range(0, 3) == 0), NC'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom_range(0, 2) == 0));
            if ($urandom_range(0, 199) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            step("R3 random compare");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: expired, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule